// File: doc/BRIEF.md
# Display Layer Shadow Reload and Interrupt Unit

This block sits beside the pixel pipeline of a display controller. Software writes new per-layer settings, such as a frame buffer base address, into shadow registers at any time, then arms a reload. The shadow values move into the active registers, which the fetch logic uses, only at the next vertical-blanking strobe. This way a frame is never scanned out with a half-updated set of settings.

The same block collects four pipeline events as sticky status flags: FIFO underrun, line reached, reload done and bus transfer error. Each flag has its own enable bit. A flag is cleared by writing a one to its bit in a clear register. One registered interrupt line reports any flag that is both set and enabled.

Top module: `disp_shadow_irq`

## Requirements
- R1: After reset all status flags, enables, the armed bit, every shadow and active value, and `irq` are zero.
- R2: A write to the shadow word of layer i (address 4+i) is read back at once. It does not change `active_base` until a reload is committed. A vertical-blanking strobe with no armed reload leaves `active_base` unchanged.
- R3: Writing the control word (address 0) with bit 0 set arms a reload from the next cycle on. At the next edge where `vblank` is high while armed, every layer's active value takes the value its shadow held before that edge.
- R4: Control bit 0 reads 1 while a reload is armed and clears itself at the commit edge, unless it is re-armed in the same cycle. Writing 0 to it does not disarm a reload.
- R5: A commit sets status bit 2 (reload done).
- R6: Status bit 0 (underrun) is set when `pix_req` is high while `fifo_empty` is high, and not when the FIFO is not empty.
- R7: `line_hit` sets status bit 1 and `bus_err` sets status bit 3. The status word is read at address 2.
- R8: Writing the clear word (address 3) clears each status flag whose bit is written as 1. Bits written as 0 have no effect, and address 3 reads as zero.
- R9: If a flag's event and its clear arrive in the same cycle, the flag stays set.
- R10: `irq` is, one cycle late, the OR of the status flags ANDed with the enable word (address 1, bits 3:0, same order as status). A disabled flag never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr` (combinational) |
| pix_req | input | 1 | Pixel output requests a pixel |
| fifo_empty | input | 1 | Pixel FIFO is empty |
| line_hit | input | 1 | Programmed line reached |
| bus_err | input | 1 | Bus error during a fetch |
| vblank | input | 1 | Vertical-blanking strobe |
| active_base | output | NUM_LAYERS*DW | Active value of each layer, layer 0 in the low word |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong armed bit shows up at the first vertical-blanking strobe: `active_base` either moves when it should hold or holds when it should move. The reload-done flag then disagrees on the following read. A wrong status or enable bit shows up on the status readback in the very next cycle and on `irq` one cycle after that. A clear/event priority error is visible right after the collision cycle. The bench runs a cycle-level model in parallel, so any such divergence is reported in the cycle it first reaches a port.

// File: rtl/disp_shadow_irq.sv
module disp_shadow_irq #(
  parameter int NUM_LAYERS = 2,
  parameter int DW = 32,
  localparam int AW = $clog2(NUM_LAYERS + 4)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic [AW-1:0]            reg_addr,
  input  logic [DW-1:0]            reg_wdata,
  output logic [DW-1:0]            reg_rdata,
  input  logic                     pix_req,
  input  logic                     fifo_empty,
  input  logic                     line_hit,
  input  logic                     bus_err,
  input  logic                     vblank,
  output logic [NUM_LAYERS*DW-1:0] active_base,
  output logic                     irq
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_IEN  = AW'(1);
  localparam logic [AW-1:0] A_STAT = AW'(2);
  localparam logic [AW-1:0] A_CLR  = AW'(3);

  logic          pend;
  logic [3:0]    en, status, ev, clr;
  logic          commit, arm;
  logic [DW-1:0] shadow [NUM_LAYERS];
  logic [DW-1:0] active [NUM_LAYERS];

  assign commit = vblank & pend;
  assign arm    = reg_wr && reg_addr == A_CTRL && reg_wdata[0];
  assign ev     = {bus_err, commit, line_hit, pix_req & fifo_empty};
  assign clr    = (reg_wr && reg_addr == A_CLR) ? reg_wdata[3:0] : 4'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      en     <= '0;
      status <= '0;
      irq    <= 1'b0;
    end else begin
      pend   <= (pend & ~vblank) | arm;
      if (reg_wr && reg_addr == A_IEN) en <= reg_wdata[3:0];
      status <= (status & ~clr) | ev;
      irq    <= |(status & en);
    end
  end

  for (genvar i = 0; i < NUM_LAYERS; i++) begin : g_layer
    localparam logic [AW-1:0] A_SH = AW'(4 + i);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow[i] <= '0;
        active[i] <= '0;
      end else begin
        if (reg_wr && reg_addr == A_SH) shadow[i] <= reg_wdata;
        if (commit) active[i] <= shadow[i];
      end
    end
    assign active_base[i*DW +: DW] = active[i];

    a_r2_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(active[i]));
    a_r3_commit_copy: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> active[i] == $past(shadow[i]));
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata[0]   = pend;
      A_IEN:   reg_rdata[3:0] = en;
      A_STAT:  reg_rdata[3:0] = status;
      default: ;
    endcase
    for (int i = 0; i < NUM_LAYERS; i++)
      if (reg_addr == AW'(4 + i)) reg_rdata = shadow[i];
  end

  a_r4_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !arm |=> !pend);
  a_r5_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> status[2]);
  a_r8_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    |(clr & ~ev) |=> (status & $past(clr & ~ev)) == 4'b0);
  a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    |(clr & ev) |=> (status & $past(clr & ev)) == $past(clr & ev));
  a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) == 4'b0 |-> !irq);
endmodule

// File: tb/disp_shadow_irq_bench.sv
module disp_shadow_irq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 2;
  localparam int DW = 32;
  localparam int AW = $clog2(NL + 4);

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic pix_req = 0, fifo_empty = 0, line_hit = 0, bus_err = 0, vblank = 0;
  logic [NL*DW-1:0] active_base;
  logic irq;

  int checks = 0, errors = 0;
  logic [DW-1:0] last_rd;

  logic m_pend, m_irq;
  logic [3:0] m_en, m_st;
  logic [DW-1:0] m_sh [NL];
  logic [DW-1:0] m_act [NL];

  disp_shadow_irq #(.NUM_LAYERS(NL), .DW(DW)) u_disp_shadow_irq (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .pix_req, .fifo_empty, .line_hit, .bus_err, .vblank,
    .active_base, .irq);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
    logic [DW-1:0] r = '0;
    if (a == 0) r[0] = m_pend;
    else if (a == 1) r[3:0] = m_en;
    else if (a == 2) r[3:0] = m_st;
    else if (a >= 4 && int'(a) < 4 + NL) r = m_sh[int'(a) - 4];
    return r;
  endfunction

  function automatic string rd_tag(input logic [AW-1:0] a);
    if (a == 0) return "R4 control";
    if (a == 1) return "R10 enable";
    if (a == 2) return "R7 status";
    if (a == 3) return "R8 clear reads zero";
    return "R2 shadow";
  endfunction

  task automatic model_reset();
    m_pend = 0; m_irq = 0; m_en = 0; m_st = 0;
    for (int i = 0; i < NL; i++) begin m_sh[i] = '0; m_act[i] = '0; end
  endtask

  task automatic step(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic pr, input logic fe, input logic lh, input logic be, input logic vb);
    logic [3:0] evm, clm, st_n;
    logic pend_n, irq_n;
    logic [DW-1:0] sh_n [NL];
    logic [DW-1:0] act_n [NL];
    @(negedge clk);
    for (int i = 0; i < NL; i++)
      chk(active_base[i*DW +: DW] == m_act[i], "R3 active_base", active_base[i*DW +: DW], m_act[i]);
    chk(irq == m_irq, "R10 irq", DW'(irq), DW'(m_irq));
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    pix_req = pr; fifo_empty = fe; line_hit = lh; bus_err = be; vblank = vb;
    #1;
    last_rd = reg_rdata;
    if (!wr) chk(reg_rdata == exp_read(a), rd_tag(a), reg_rdata, exp_read(a));
    evm = {be, vb & m_pend, lh, pr & fe};
    clm = (wr && a == 3) ? d[3:0] : 4'b0;
    st_n = (m_st & ~clm) | evm;
    irq_n = |(m_st & m_en);
    pend_n = (vb ? 1'b0 : m_pend) | (wr && a == 0 && d[0]);
    for (int i = 0; i < NL; i++) begin
      sh_n[i] = (wr && int'(a) == 4 + i) ? d : m_sh[i];
      act_n[i] = (vb && m_pend) ? m_sh[i] : m_act[i];
    end
    @(posedge clk);
    m_st = st_n; m_irq = irq_n; m_pend = pend_n;
    if (wr && a == 1) m_en = d[3:0];
    for (int i = 0; i < NL; i++) begin m_sh[i] = sh_n[i]; m_act[i] = act_n[i]; end
  endtask

  task automatic idle_rd(input logic [AW-1:0] a);
    step(0, a, '0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    chk(active_base == '0, "R1 active after reset", active_base[DW-1:0], '0);
    chk(irq == 1'b0, "R1 irq after reset", DW'(irq), '0);
    idle_rd(2);
    chk(last_rd == '0, "R1 status after reset", last_rd, '0);

    // R2 shadow write without arm; vblank does nothing
    step(1, 4, 32'hA5A5_0001, 0, 0, 0, 0, 0);
    step(0, 4, '0, 0, 0, 0, 0, 1);
    idle_rd(4);
    chk(active_base[DW-1:0] == '0, "R2 no commit without arm", active_base[DW-1:0], '0);
    chk(last_rd == 32'hA5A5_0001, "R2 shadow readback", last_rd, 32'hA5A5_0001);

    // R3 R4 R5 arm then commit
    step(1, 0, 32'h1, 0, 0, 0, 0, 0);
    step(1, 0, 32'h0, 0, 0, 0, 0, 0);
    idle_rd(0);
    chk(last_rd[0] == 1'b1, "R4 armed reads 1, zero write ignored", last_rd, 1);
    step(0, 0, '0, 0, 0, 0, 0, 1);
    idle_rd(0);
    chk(active_base[DW-1:0] == 32'hA5A5_0001, "R3 commit at vblank", active_base[DW-1:0], 32'hA5A5_0001);
    chk(last_rd[0] == 1'b0, "R4 self clear", last_rd, 0);
    idle_rd(2);
    chk(last_rd[2] == 1'b1, "R5 reload done flag", last_rd, 32'h4);

    // R10 R7 line disabled
    step(1, 3, 32'hF, 0, 0, 0, 0, 0);
    step(1, 1, 32'hD, 0, 0, 0, 0, 0);
    step(0, 2, '0, 0, 0, 1, 0, 0);
    idle_rd(2);
    idle_rd(2);
    chk(irq == 1'b0, "R10 disabled line flag masked", DW'(irq), 0);
    chk(last_rd[1] == 1'b1, "R7 line flag", last_rd, 32'h2);

    // R6 underrun
    step(0, 2, '0, 1, 0, 0, 0, 0);
    idle_rd(2);
    chk(last_rd[0] == 1'b0, "R6 no underrun with data", last_rd, 32'h2);
    step(0, 2, '0, 1, 1, 0, 0, 0);
    idle_rd(2);
    chk(last_rd[0] == 1'b1, "R6 underrun flag", last_rd, 32'h3);
    idle_rd(2);
    chk(irq == 1'b1, "R10 irq raised", DW'(irq), 1);

    // R8 zero write, R9 collision
    step(1, 3, 32'h0, 0, 0, 0, 0, 0);
    idle_rd(2);
    chk(last_rd[3:0] == 4'h3, "R8 zero clear no effect", last_rd, 32'h3);
    step(1, 3, 32'hF, 0, 0, 0, 1, 0);
    idle_rd(2);
    chk(last_rd[3:0] == 4'h8, "R9 event beats clear", last_rd, 32'h8);
    chk(irq == 1'b1, "R10 irq with bus error", DW'(irq), 1);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic wr;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      wr = ($urandom % 2) == 0;
      a = AW'($urandom % (NL + 5));
      d = $urandom;
      if (a == 3 && ($urandom % 3) != 0) d = '0;
      step(wr, a, d, ($urandom % 5) == 0, ($urandom % 2) == 0, ($urandom % 7) == 0,
           ($urandom % 9) == 0, ($urandom % 6) == 0);
    end
    idle_rd(0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule